// File: doc/BRIEF.md
# Synchronous serial byte shifter

This block moves one byte at a time over a three-wire synchronous link made of a serial clock, a data output and a data input. One 8-bit register serves both directions. Bits leave on the output line while incoming bits enter at the other end, so after eight clock periods the register holds the received byte. Software starts a transfer in one of two ways. Writing a byte loads the register and starts shifting. Reading the current byte starts a fresh transfer that keeps the old contents as the outgoing data.

The serial clock comes from one of four sources, chosen by a two-bit field. With the external setting the clock pin is an input and the block follows its rising edges. The three internal settings drive the pin as an output: a programmable terminal-count divider, the system clock divided by four, or the system clock divided by two. Two independent enables, one for transmit and one for receive, gate all shifting. A order bit chooses whether the most or the least significant bit travels first.

Top module: `sio_shifter`

## Requirements
- R1: After reset: busy low, done low, the serial clock output high, the clock pin not driven (the external setting 00 is selected) and the data output high.
- R2: The clock pin is driven (sck_oe high) for clock-select codes 01, 10 and 11, and released (sck_oe low) for code 00.
- R3: The serial clock idles high. For an internal source a transfer lasts 16 half periods. A half period is 1 system clock for code 11, 2 for code 10 and BAUD_DIV for code 01, so done rises 16, 32 or 16*BAUD_DIV cycles after the start is registered.
- R4: With the order bit 0 (MSB first), sdo presents bit 7 of the loaded byte from the start of the transfer. It moves to the next lower bit on each falling serial-clock edge after the first. sdi is sampled on each rising edge, and the first sampled bit lands in bit 7 of the received byte.
- R5: With the order bit 1 (LSB first), bit 0 is sent first and the first sampled bit lands in bit 0.
- R6: A byte write starts a transfer when either enable is 1 and no transfer is running. A read strobe starts one when the receive enable is 1 and no transfer is running.
- R7: busy is high from the cycle after the start until done. done is a single-cycle pulse after the eighth rising edge, and busy falls in that same cycle.
- R8: A byte write while busy is ignored. The transfer in progress and its received byte are unchanged.
- R9: The clock-select field only takes a new value when both enables were 0 before the control write. Otherwise that field of the write is ignored.
- R10: With both enables 0, neither strobe starts a transfer and the data register does not change.
- R11: In the external setting, the shifter follows rising and falling edges of sck_in after a two-flop synchronizer, and completes after eight rising edges.
- R12: With the transmit enable 0, sdo stays high. With the receive enable 0, zeros are shifted in instead of sdi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_tx_en | input | 1 | Transmit enable value |
| ctl_rx_en | input | 1 | Receive enable value |
| ctl_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| ctl_clk_sel | input | 2 | Clock source: 00 external, 01 divider, 10 clk/4, 11 clk/2 |
| wr_stb | input | 1 | Byte write strobe (starts transmit) |
| wr_byte | input | 8 | Byte to load |
| rd_stb | input | 1 | Byte read strobe (starts receive) |
| rd_byte | output | 8 | Current data register contents |
| sck_in | input | 1 | Clock pin input (external setting) |
| sck_out | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin drive enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a control write that tries to change the clock source while shifting is enabled. The rejection only shows afterwards, as an unchanged pin direction and an unchanged transfer length. The stimulus therefore enables a divided-clock mode, writes the external code, and then times a read-started transfer against the length of the old mode. The external-clock path needs its own hand-paced edge sequence with four system clocks per level, so that synchronizer latency cannot hide a dropped or doubled edge. A byte write is also injected in the middle of a divider-paced transfer.

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int BAUD_DIV = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_tx_en,
  input  logic       ctl_rx_en,
  input  logic       ctl_lsb_first,
  input  logic [1:0] ctl_clk_sel,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_stb,
  output logic [7:0] rd_byte,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  output logic       sdo,
  input  logic       sdi,
  output logic       busy,
  output logic       done
);

  localparam int CW = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;

  logic          tx_en, rx_en, lsb_first;
  logic [1:0]    clk_sel;
  logic [7:0]    sreg;
  logic          rx_bit;
  logic [3:0]    nrise;
  logic [CW-1:0] hcnt;
  logic [CW-1:0] half_m1;
  logic          sck_q;
  logic [2:0]    ext_sy;

  function automatic logic [7:0] shift_in(input logic [7:0] r, input logic b, input logic lsb);
    return lsb ? {b, r[7:1]} : {r[6:0], b};
  endfunction

  wire any_en   = tx_en || rx_en;
  wire ext_mode = (clk_sel == 2'b00);
  wire run      = busy && any_en;

  always_comb begin
    case (clk_sel)
      2'b01:   half_m1 = CW'(BAUD_DIV - 1);
      2'b10:   half_m1 = CW'(1);
      default: half_m1 = '0;
    endcase
  end

  wire tick     = run && !ext_mode && (hcnt >= half_m1);
  wire ev_fall  = ext_mode ? (run && !ext_sy[1] && ext_sy[2]) : (tick && sck_q);
  wire ev_rise  = ext_mode ? (run && ext_sy[1] && !ext_sy[2]) : (tick && !sck_q);
  wire start_wr = wr_stb && !busy && any_en;
  wire start_rd = !start_wr && rd_stb && !busy && rx_en;
  wire last     = ev_rise && (nrise == 4'd7);
  wire in_now   = sdi && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      lsb_first <= 1'b0;
      clk_sel   <= 2'b00;
      sreg      <= '0;
      rx_bit    <= 1'b0;
      nrise     <= '0;
      hcnt      <= '0;
      sck_q     <= 1'b1;
      ext_sy    <= 3'b111;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      ext_sy <= {ext_sy[1:0], sck_in};
      done   <= last;
      if (ctl_we) begin
        tx_en     <= ctl_tx_en;
        rx_en     <= ctl_rx_en;
        lsb_first <= ctl_lsb_first;
        if (!any_en) clk_sel <= ctl_clk_sel;
      end
      if (start_wr || start_rd) begin
        busy  <= 1'b1;
        nrise <= '0;
        hcnt  <= '0;
        sck_q <= 1'b1;
        if (start_wr) sreg <= wr_byte;
      end else if (run) begin
        if (!ext_mode) hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) sck_q <= ~sck_q;
        if (ev_rise) begin
          nrise  <= nrise + 4'd1;
          rx_bit <= in_now;
        end
        if (ev_fall && nrise != 4'd0) sreg <= shift_in(sreg, rx_bit, lsb_first);
        if (last) begin
          sreg <= shift_in(sreg, in_now, lsb_first);
          busy <= 1'b0;
        end
      end
    end
  end

  assign rd_byte = sreg;
  assign sck_out = ext_mode ? 1'b1 : sck_q;
  assign sck_oe  = !ext_mode;
  assign sdo     = (busy && tx_en) ? (lsb_first ? sreg[0] : sreg[7]) : 1'b1;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R7
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (tx_en || rx_en) |=> $stable(clk_sel)); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck_out); // R3
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && !rx_en) |=> $stable(sreg)); // R10
  AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (nrise <= 4'd7)); // R7

endmodule

// File: tb/tb_sio_shifter.sv
module tb_sio_shifter;
  localparam int BAUD = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0, ctl_tx_en = 1'b0, ctl_rx_en = 1'b0, ctl_lsb_first = 1'b0;
  logic [1:0] ctl_clk_sel = 2'b00;
  logic       wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_byte;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe, sdo, busy, done;
  logic       ext_drive = 1'b0, ext_sdi = 1'b0, rnd_sdi = 1'b0;
  wire        sdi = ext_drive ? ext_sdi : rnd_sdi;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0;

  sio_shifter #(.BAUD_DIV(BAUD)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_tx_en(ctl_tx_en), .ctl_rx_en(ctl_rx_en),
    .ctl_lsb_first(ctl_lsb_first), .ctl_clk_sel(ctl_clk_sel), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_stb(rd_stb), .rd_byte(rd_byte), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdo(sdo), .sdi(sdi), .busy(busy), .done(done));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (cyc == 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  always @(negedge clk) rnd_sdi <= 1'($urandom);

  // behavioural reference model
  bit m_tx, m_rx, m_lsb, m_busy, m_done, m_sck, m_known, m_en, m_go_wr, m_go_rd;
  bit [1:0] m_sel;
  bit [7:0] m_byte;
  int m_timer, m_nrise;
  bit tx_q[$];
  bit rx_q[$];

  function automatic int half_of(input bit [1:0] s);
    return (s == 2'b01) ? BAUD : (s == 2'b10) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_lsb = 0; m_sel = 0; m_busy = 0; m_done = 0; m_sck = 1;
      m_timer = 0; m_nrise = 0; m_known = 0; m_byte = 0;
      tx_q.delete(); rx_q.delete();
    end else begin
      m_en = m_tx || m_rx;
      m_done = 0;
      if (m_sel != 2'b00) begin
        m_go_wr = wr_stb && !m_busy && m_en;
        m_go_rd = !m_go_wr && rd_stb && !m_busy && m_rx;
        if (m_go_wr || m_go_rd) begin
          if (m_go_wr) begin m_byte = wr_byte; m_known = 1; end
          m_busy = 1; m_timer = 0; m_nrise = 0; m_sck = 1;
          tx_q.delete(); rx_q.delete();
          for (int i = 0; i < 8; i++) tx_q.push_back(m_lsb ? m_byte[i] : m_byte[7-i]);
        end else if (m_busy && m_en) begin
          m_timer++;
          if (m_timer == half_of(m_sel)) begin
            m_timer = 0;
            if (m_sck) begin
              m_sck = 0;
              if (m_nrise > 0) void'(tx_q.pop_front());
            end else begin
              m_sck = 1;
              m_nrise++;
              rx_q.push_back(m_rx ? sdi : 1'b0);
              if (m_nrise == 8) begin
                m_busy = 0; m_done = 1; m_known = 1;
                for (int i = 0; i < 8; i++) begin
                  if (m_lsb) m_byte[i] = rx_q[i];
                  else m_byte[7-i] = rx_q[i];
                end
              end
            end
          end
        end
      end
      if (ctl_we) begin
        if (!m_en) m_sel = ctl_clk_sel;
        m_tx = ctl_tx_en; m_rx = ctl_rx_en; m_lsb = ctl_lsb_first;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ext_drive && m_sel != 2'b00) begin
      check("R7 busy", busy, m_busy);
      check("R7 done", done, m_done);
      check("R3 sck_out", sck_out, m_sck);
      check("R2 sck_oe", sck_oe, 1);
      check(m_tx ? "R4 sdo" : "R12 sdo", sdo, (m_busy && m_tx) ? tx_q[0] : 1'b1);
      if (!m_busy && m_known) check(m_lsb ? "R5 rd_byte" : "R4 rd_byte", rd_byte, m_byte);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input bit tx, input bit rx, input bit lsb, input bit [1:0] sel);
    ctl_we = 1; ctl_tx_en = tx; ctl_rx_en = rx; ctl_lsb_first = lsb; ctl_clk_sel = sel;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wr(input bit [7:0] b);
    wr_stb = 1; wr_byte = b;
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic rd();
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    int len;
    bit [7:0] keep;
    int dc;
    step(3);
    rst_n = 1;
    step(1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 sck_out", sck_out, 1);
    check("R1 sck_oe", sck_oe, 0);
    check("R1 sdo", sdo, 1);

    ctl(1, 1, 0, 2'b11);
    check("R2 oe code 11", sck_oe, 1);
    wr(8'hA5);
    check("R6 write starts", busy, 1);
    wait_done(len);
    check("R3 clk/2 length", len, 16);
    step(1);
    check("R4 msb byte", rd_byte, m_byte);

    ctl(0, 0, 1, 2'b11);
    ctl(1, 1, 1, 2'b10);
    wr(8'h3C);
    wait_done(len);
    check("R3 clk/4 length", len, 32);
    step(1);
    check("R5 lsb byte", rd_byte, m_byte);

    ctl(1, 1, 1, 2'b00);
    check("R9 sel locked oe", sck_oe, 1);
    rd();
    check("R6 read starts", busy, 1);
    wait_done(len);
    check("R9 sel locked length", len, 32);
    step(1);

    ctl(0, 0, 0, 2'b01);
    check("R2 oe code 01", sck_oe, 1);
    ctl(1, 1, 0, 2'b01);
    wr(8'h5A);
    wait_done(len);
    check("R3 divider length", len, 16 * BAUD);
    step(1);
    wr(8'h69);
    step(20);
    wr(8'hFF);
    check("R8 still busy", busy, 1);
    wait_done(len);
    step(1);
    check("R8 byte kept", rd_byte, m_byte);

    ctl(0, 0, 0, 2'b01);
    keep = rd_byte;
    wr(8'h77);
    check("R10 write no start", busy, 0);
    rd();
    check("R10 read no start", busy, 0);
    step(5);
    check("R10 data frozen", rd_byte, keep);
    check("R10 sdo idle", sdo, 1);

    ctl(0, 1, 0, 2'b11);
    rd();
    step(5);
    check("R12 sdo high rx only", sdo, 1);
    wait_done(len);
    step(1);
    check("R12 rx only byte", rd_byte, m_byte);
    ctl(1, 0, 0, 2'b11);
    wr(8'hC3);
    wait_done(len);
    step(1);
    check("R12 zeros shifted in", rd_byte, 0);

    ctl(0, 0, 0, 2'b00);
    ctl(1, 1, 0, 2'b00);
    check("R2 oe code 00", sck_oe, 0);
    ext_drive = 1;
    wr(8'h3C);
    dc = done_cnt;
    for (int i = 0; i < 8; i++) begin
      sck_in = 0;
      ext_sdi = (8'h96 >> (7 - i)) & 1;
      step(4);
      check("R11 ext sdo bit", sdo, (8'h3C >> (7 - i)) & 1);
      sck_in = 1;
      step(4);
      if (i == 6) check("R11 busy after seven", busy, 1);
    end
    step(2);
    check("R11 ext finished", busy, 0);
    check("R11 ext one done", done_cnt - dc, 1);
    check("R11 ext byte", rd_byte, 8'h96);
    finish_run();
  end
endmodule